// File: doc/BRIEF.md
# PLL Reconfiguration and Relock Supervisor

This block stands between a command port and the parameter inputs of a reconfigurable PLL. A request carries a feedback multiplier, a reference divider, the high and low halves of the post-scale count, and a phase setting. The supervisor first checks the request: the input frequency times the multiplier, divided by the divider, must land inside the allowed VCO window. Only a request that passes is written to the PLL parameter outputs. The block then issues a one-cycle reconfigure strobe.

When the multiplier or the divider changes, the PLL loses lock. The supervisor then holds the PLL reset for a fixed number of cycles and waits for lock to return. A change to only the post-scale halves or the phase keeps the loop locked, so no reset is issued for it. In every case success is reported only after lock has been seen through a two-flop synchronizer. While the block is idle it also watches the lock input. If lock drops on its own, the block resets the PLL and waits for it to settle again. If lock does not return within a programmable number of cycles, the block retries the reset once and then gives up with an error.

The window check uses only multiplication. The block compares `IN_MHZ*M` against `VCO_MIN_MHZ*N` and `VCO_MAX_MHZ*N`. The output frequency is the VCO frequency divided by the post-scale count, which is the sum of its high and low halves.

Top module: `pll_relock_sup`

## Requirements
- R1: A request is rejected unless M and N are both nonzero and `VCO_MIN_MHZ*N <= IN_MHZ*M <= VCO_MAX_MHZ*N` (defaults 50, 300 and 1040; for example 5/1, 21/1 and 105/5 fail, while 6/1 and 104/5 pass). A rejection gives a one-cycle `error` pulse with `err_range` high, no `cfg_write`, no `reconfig_pulse`, no `pll_reset`, and leaves the `cfg_*` outputs unchanged.
- R2: An accepted request sets all `cfg_*` outputs to the requested values, which stay stable until the next accepted request. `cfg_write` is high for one cycle while the new values are shown, and `reconfig_pulse` is high for exactly the following cycle. After reset the `cfg_*` outputs hold the defaults (M=12, N=1, high=2, low=2, phase=0).
- R3: When the accepted M or N differs from the current value, `pll_reset` rises in the cycle after `reconfig_pulse` and stays high for exactly `RST_CYCLES` (512) cycles.
- R4: An accepted request that changes only the post-scale halves or the phase raises no `pll_reset`.
- R5: `done` is issued only after the synchronized lock is seen high. The `lock_in` input has therefore been high for at least three clock cycles when `done` appears.
- R6: A fall of lock while the block is idle and not busy raises `pll_reset` for exactly `RST_CYCLES` cycles. After that, lock is awaited again without any `done` pulse and with `busy` low.
- R7: If lock has not returned `timeout_cycles` cycles after a reset hold ends, `err_timeout` pulses and the reset hold is repeated once. A second expiry ends the sequence with an `error` pulse that has `err_range` low.
- R8: `busy` goes high in the cycle after a request is accepted and stays high through the `done` or `error` cycle. It is low in the next cycle. `done` and `error` each last one cycle, and they are never high together.
- R9: A `req_valid` that arrives while the block is busy is ignored. The `cfg_*` outputs keep the values of the accepted request, and no second `reconfig_pulse` follows.
- R10: `lock_in` passes through two flops before any decision uses it. A fall of lock while idle therefore shows on `pll_reset` three clock edges later, and not two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_mult | input | MW | Requested feedback multiplier M |
| req_div | input | NW | Requested reference divider N |
| req_hi | input | CW | Requested post-scale high time |
| req_lo | input | CW | Requested post-scale low time |
| req_phase | input | PW | Requested phase setting |
| timeout_cycles | input | TW | Lock wait limit after each reset hold |
| lock_in | input | 1 | PLL lock indication (asynchronous) |
| cfg_mult | output | MW | Applied multiplier |
| cfg_div | output | NW | Applied divider |
| cfg_hi | output | CW | Applied post-scale high time |
| cfg_lo | output | CW | Applied post-scale low time |
| cfg_phase | output | PW | Applied phase setting |
| cfg_write | output | 1 | Parameter load strobe |
| reconfig_pulse | output | 1 | Final reconfigure strobe |
| pll_reset | output | 1 | PLL reset |
| busy | output | 1 | Update in progress |
| done | output | 1 | Update completed with lock |
| error | output | 1 | Update or recovery failed |
| err_range | output | 1 | With error: VCO window violated |
| err_timeout | output | 1 | Lock wait expired |

## Verification
Some properties are checked on every cycle. The reconfigure strobe always follows the write strobe. The parameter outputs change only with a write. Every rising `pll_reset` has a legal cause: an M/N change, a retry or a recovery. A reset hold always ends at its full length. `done` always comes after synchronized lock. The completion pulses last one cycle and never overlap. Other behaviour can only be shown by the bench scenarios. These are the exact arithmetic limits of the VCO window, the reset width of 512 cycles counted at the pins, and the synchronizer latency after a lock drop. They also include the single retry followed by a failure, and the dropping of requests that arrive while the block is busy.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_PULSE,
        ST_RESET_HOLD,
        ST_WAIT_LOCK,
        ST_DONE,
        ST_ERROR
    } sup_state_e;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pll_vco_check.sv
module pll_vco_check #(
    parameter int IN_MHZ      = 50,
    parameter int VCO_MIN_MHZ = 300,
    parameter int VCO_MAX_MHZ = 1040,
    parameter int MW          = 9,
    parameter int NW          = 9
) (
    input  logic [MW-1:0] mult,
    input  logic [NW-1:0] div,
    output logic          in_range
);
    localparam int PW = 40;
    logic [PW-1:0] vco_scaled, lo_bound, hi_bound;

    always_comb begin
        vco_scaled = PW'(IN_MHZ) * PW'(mult);
        lo_bound   = PW'(VCO_MIN_MHZ) * PW'(div);
        hi_bound   = PW'(VCO_MAX_MHZ) * PW'(div);
        in_range   = (mult != '0) && (div != '0) &&
                     (vco_scaled >= lo_bound) && (vco_scaled <= hi_bound);
    end
endmodule

// File: rtl/pll_relock_sup.sv
module pll_relock_sup
    import pll_sup_pkg::*;
#(
    parameter int IN_MHZ      = 50,
    parameter int VCO_MIN_MHZ = 300,
    parameter int VCO_MAX_MHZ = 1040,
    parameter int MW          = 9,
    parameter int NW          = 9,
    parameter int CW          = 8,
    parameter int PW          = 8,
    parameter int TW          = 16,
    parameter int RST_CYCLES  = 512,
    parameter int DEF_MULT    = 12,
    parameter int DEF_DIV     = 1,
    parameter int DEF_HI      = 2,
    parameter int DEF_LO      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [MW-1:0] req_mult,
    input  logic [NW-1:0] req_div,
    input  logic [CW-1:0] req_hi,
    input  logic [CW-1:0] req_lo,
    input  logic [PW-1:0] req_phase,
    input  logic [TW-1:0] timeout_cycles,
    input  logic          lock_in,
    output logic [MW-1:0] cfg_mult,
    output logic [NW-1:0] cfg_div,
    output logic [CW-1:0] cfg_hi,
    output logic [CW-1:0] cfg_lo,
    output logic [PW-1:0] cfg_phase,
    output logic          cfg_write,
    output logic          reconfig_pulse,
    output logic          pll_reset,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          err_range,
    output logic          err_timeout
);
    localparam int HW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [MW-1:0] mult;
        logic [NW-1:0] div;
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
        logic [PW-1:0] phase;
    } cnt_set_t;

    typedef struct packed {
        sup_state_e    st;
        cnt_set_t      req;
        cnt_set_t      cfg;
        logic          need_rst;
        logic          retry;
        logic          recov;
        logic          range_fail;
        logic          busy;
        logic          tmo_pulse;
        logic          lock_prev;
        logic [HW-1:0] hold;
        logic [TW-1:0] tmo;
    } regs_t;

    regs_t r_d, r_q;
    logic  lock_s;
    logic  vco_ok;
    logic  tmo_expired;

    pll_lock_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lock_in),
        .sync_out (lock_s)
    );

    pll_vco_check #(
        .IN_MHZ(IN_MHZ), .VCO_MIN_MHZ(VCO_MIN_MHZ), .VCO_MAX_MHZ(VCO_MAX_MHZ),
        .MW(MW), .NW(NW)
    ) u_vco (
        .mult     (r_q.req.mult),
        .div      (r_q.req.div),
        .in_range (vco_ok)
    );

    assign tmo_expired = ({1'b0, r_q.tmo} + 1'b1) >= {1'b0, timeout_cycles};

    always_comb begin
        r_d           = r_q;
        r_d.tmo_pulse = 1'b0;
        r_d.lock_prev = lock_s;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.req        = '{mult: req_mult, div: req_div, hi: req_hi,
                                       lo: req_lo, phase: req_phase};
                    r_d.busy       = 1'b1;
                    r_d.recov      = 1'b0;
                    r_d.retry      = 1'b0;
                    r_d.range_fail = 1'b0;
                    r_d.st         = ST_CHECK;
                end else if (r_q.lock_prev && !lock_s) begin
                    r_d.recov      = 1'b1;
                    r_d.retry      = 1'b0;
                    r_d.range_fail = 1'b0;
                    r_d.hold       = '0;
                    r_d.st         = ST_RESET_HOLD;
                end
            end
            ST_CHECK: begin
                if (!vco_ok) begin
                    r_d.range_fail = 1'b1;
                    r_d.st         = ST_ERROR;
                end else begin
                    r_d.need_rst = (r_q.req.mult != r_q.cfg.mult) ||
                                   (r_q.req.div  != r_q.cfg.div);
                    r_d.cfg      = r_q.req;
                    r_d.st       = ST_WRITE;
                end
            end
            ST_WRITE: r_d.st = ST_PULSE;
            ST_PULSE: begin
                r_d.hold = '0;
                r_d.tmo  = '0;
                r_d.st   = r_q.need_rst ? ST_RESET_HOLD : ST_WAIT_LOCK;
            end
            ST_RESET_HOLD: begin
                if (r_q.hold == HW'(RST_CYCLES - 1)) begin
                    r_d.tmo = '0;
                    r_d.st  = ST_WAIT_LOCK;
                end else begin
                    r_d.hold = r_q.hold + 1'b1;
                end
            end
            ST_WAIT_LOCK: begin
                if (lock_s) begin
                    r_d.st = r_q.recov ? ST_IDLE : ST_DONE;
                end else if (tmo_expired) begin
                    r_d.tmo_pulse = 1'b1;
                    if (!r_q.retry) begin
                        r_d.retry = 1'b1;
                        r_d.hold  = '0;
                        r_d.st    = ST_RESET_HOLD;
                    end else begin
                        r_d.st = ST_ERROR;
                    end
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            ST_DONE: begin
                r_d.busy = 1'b0;
                r_d.st   = ST_IDLE;
            end
            ST_ERROR: begin
                r_d.busy = 1'b0;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.cfg <= '{mult: MW'(DEF_MULT), div: NW'(DEF_DIV), hi: CW'(DEF_HI),
                         lo: CW'(DEF_LO), phase: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_mult       = r_q.cfg.mult;
    assign cfg_div        = r_q.cfg.div;
    assign cfg_hi         = r_q.cfg.hi;
    assign cfg_lo         = r_q.cfg.lo;
    assign cfg_phase      = r_q.cfg.phase;
    assign cfg_write      = (r_q.st == ST_WRITE);
    assign reconfig_pulse = (r_q.st == ST_PULSE);
    assign pll_reset      = (r_q.st == ST_RESET_HOLD);
    assign busy           = r_q.busy;
    assign done           = (r_q.st == ST_DONE);
    assign error          = (r_q.st == ST_ERROR);
    assign err_range      = error && r_q.range_fail;
    assign err_timeout    = r_q.tmo_pulse;

    // R1: a range error is decided in the check step, without a strobe
    p_range_from_check_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> ($past(r_q.st) == ST_CHECK) && !$past(reconfig_pulse));

    // R2: the reconfigure strobe follows the load strobe by one cycle
    p_pulse_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write |=> reconfig_pulse);

    // R2: the applied values move only alongside the load strobe
    p_cfg_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_write |-> $stable(cfg_mult) && $stable(cfg_div) && $stable(cfg_hi)
                       && $stable(cfg_lo) && $stable(cfg_phase));

    // R3: each reset hold ends only after its full length
    p_reset_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_reset) |-> $past(r_q.hold) == HW'(RST_CYCLES - 1));

    // R4: a reset starts only for an M/N change, a retry or a recovery
    p_reset_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_reset) |-> ($past(reconfig_pulse) && r_q.need_rst) || err_timeout || r_q.recov);

    // R5: completion only after the synchronized lock is high
    p_done_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(lock_s));

    // R7: a timeout leads to a retry hold or to the final error
    p_timeout_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> pll_reset || error);

    // R8: completion pulses last one cycle, and busy covers the done cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 (!done && !busy));
    p_error_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error && !busy);
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
endmodule

// File: tb/tb_pll_relock_sup.sv
module tb_pll_relock_sup;
    localparam int MW = 9, NW = 9, CW = 8, PW = 8, TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [MW-1:0] req_mult = '0;
    logic [NW-1:0] req_div = '0;
    logic [CW-1:0] req_hi = '0;
    logic [CW-1:0] req_lo = '0;
    logic [PW-1:0] req_phase = '0;
    logic [TW-1:0] timeout_cycles = 16'd400;
    logic          lock_in;
    logic [MW-1:0] cfg_mult;
    logic [NW-1:0] cfg_div;
    logic [CW-1:0] cfg_hi, cfg_lo;
    logic [PW-1:0] cfg_phase;
    logic cfg_write, reconfig_pulse, pll_reset, busy, done, error, err_range, err_timeout;

    pll_relock_sup dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mult(req_mult),
        .req_div(req_div), .req_hi(req_hi), .req_lo(req_lo), .req_phase(req_phase),
        .timeout_cycles(timeout_cycles), .lock_in(lock_in), .cfg_mult(cfg_mult),
        .cfg_div(cfg_div), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_phase(cfg_phase),
        .cfg_write(cfg_write), .reconfig_pulse(reconfig_pulse), .pll_reset(pll_reset),
        .busy(busy), .done(done), .error(error), .err_range(err_range),
        .err_timeout(err_timeout)
    );

    always #4 clk = ~clk;

    // PLL model: lock returns a programmable delay after reset is released
    logic lock_reg = 1'b0;
    int   settle_cnt = 0;
    int   settle_dly = 20;
    logic force_low = 1'b0;
    always @(posedge clk) begin
        if (!rst_n || pll_reset) begin
            lock_reg   <= 1'b0;
            settle_cnt <= 0;
        end else if (!lock_reg) begin
            if (settle_cnt >= settle_dly) lock_reg <= 1'b1;
            else settle_cnt <= settle_cnt + 1;
        end
    end
    assign lock_in = lock_reg && !force_low;

    int checks = 0, errors = 0;
    int cyc = 0, w_cyc = 0, p_cyc = 0;
    int n_pulse, n_write, n_rst_ep, last_w, cur_w, n_done, n_err, n_rng, n_tmo;
    int lock_run = 0, run_at_done = 0, busy_at_done = 0;
    logic rst_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (cfg_write) begin w_cyc = cyc; n_write++; end
        if (reconfig_pulse) begin p_cyc = cyc; n_pulse++; end
        if (pll_reset) cur_w++;
        else if (rst_prev) begin last_w = cur_w; cur_w = 0; n_rst_ep++; end
        rst_prev = pll_reset;
        lock_run = lock_in ? lock_run + 1 : 0;
        if (done) begin n_done++; run_at_done = lock_run; busy_at_done = busy; end
        if (error) n_err++;
        if (err_range) n_rng++;
        if (err_timeout) n_tmo++;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        n_pulse = 0; n_write = 0; n_rst_ep = 0; last_w = 0; cur_w = 0;
        n_done = 0; n_err = 0; n_rng = 0; n_tmo = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int m, input int n, input int hi, input int lo, input int ph);
        req_valid = 1'b1;
        req_mult = MW'(m); req_div = NW'(n);
        req_hi = CW'(hi); req_lo = CW'(lo); req_phase = PW'(ph);
        tick();
        req_valid = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        int k = 0;
        while (n_done + n_err == 0 && k < limit) begin tick(); k++; end
        if (k >= limit) check(1'b0, "R8 completion", k, limit);
        repeat (3) tick();
    endtask

    task automatic wait_locked();
        int k = 0;
        while (!lock_in && k < 2000) begin tick(); k++; end
        repeat (5) tick();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check(busy == 1'b0 && pll_reset == 1'b0, "R8 reset idle", int'(busy), 0);
        check(done == 1'b0 && error == 1'b0, "R8 reset no pulse", int'(done | error), 0);
        check(cfg_mult == 12 && cfg_div == 1 && cfg_hi == 2, "R2 reset defaults",
              int'(cfg_mult), 12);
        wait_locked();
    endtask

    task automatic t_range_reject();
        int bad_m[5] = '{5, 21, 105, 0, 6};
        int bad_n[5] = '{1, 1, 5, 1, 0};
        for (int i = 0; i < 5; i++) begin
            clear_mon();
            send(bad_m[i], bad_n[i], 4, 4, 1);
            wait_end(50);
            repeat (5) tick();
            check(n_err == 1 && n_rng == 1, "R1 reject flagged", n_rng, 1);
            check(n_pulse == 0 && n_write == 0 && n_rst_ep == 0, "R1 reject no strobes",
                  n_pulse + n_write + n_rst_ep, 0);
            check(cfg_mult == 12 && cfg_hi == 2, "R1 cfg unchanged", int'(cfg_mult), 12);
            check(busy == 1'b0, "R8 busy low after error", int'(busy), 0);
        end
    endtask

    task automatic t_accept(input int m, input int n, input int hi);
        clear_mon();
        send(m, n, hi, 3, 0);
        check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        wait_end(3000);
        check(n_done == 1 && n_err == 0, "R1 accepted", n_done, 1);
        check(n_pulse == 1 && p_cyc == w_cyc + 1, "R2 pulse after write", p_cyc - w_cyc, 1);
        check(cfg_mult == MW'(m) && cfg_div == NW'(n) && cfg_hi == CW'(hi),
              "R2 cfg applied", int'(cfg_mult), m);
        check(n_rst_ep == 1, "R3 one reset", n_rst_ep, 1);
        check(last_w == 512, "R3 reset width", last_w, 512);
        check(run_at_done >= 3, "R5 lock before done", run_at_done, 3);
        check(busy_at_done == 1 && busy == 1'b0, "R8 busy span", busy_at_done, 1);
    endtask

    task automatic t_postscale();
        clear_mon();
        send(104, 5, 7, 1, 9);
        wait_end(200);
        check(n_done == 1, "R4 done without reset", n_done, 1);
        check(n_rst_ep == 0 && pll_reset == 1'b0, "R4 no reset", n_rst_ep, 0);
        check(cfg_hi == 7 && cfg_lo == 1 && cfg_phase == 9, "R4 cfg updated", int'(cfg_phase), 9);
    endtask

    task automatic t_busy_ignore();
        clear_mon();
        send(20, 1, 2, 2, 0);
        repeat (10) tick();
        send(6, 1, 5, 5, 5);
        wait_end(3000);
        repeat (20) tick();
        check(cfg_mult == 20 && cfg_hi == 2 && cfg_phase == 0, "R9 busy request dropped",
              int'(cfg_mult), 20);
        check(n_pulse == 1 && n_done == 1, "R9 single update", n_pulse, 1);
    endtask

    task automatic t_lock_loss();
        int k = 0;
        wait_locked();
        clear_mon();
        force_low = 1'b1;
        tick();
        tick();
        check(pll_reset == 1'b0, "R10 two-edge latency", int'(pll_reset), 0);
        tick();
        check(pll_reset == 1'b1, "R10 reset on third edge", int'(pll_reset), 1);
        check(busy == 1'b0, "R6 recovery not busy", int'(busy), 0);
        force_low = 1'b0;
        while ((n_rst_ep == 0 || !lock_in) && k < 3000) begin tick(); k++; end
        repeat (10) tick();
        check(n_rst_ep == 1 && last_w == 512, "R6 recovery reset width", last_w, 512);
        check(n_done == 0 && n_err == 0 && busy == 1'b0, "R6 no done on recovery", n_done, 0);
    endtask

    task automatic t_timeout();
        timeout_cycles = 16'd100;
        clear_mon();
        send(12, 1, 2, 2, 0);
        force_low = 1'b1;
        wait_end(4000);
        check(n_tmo == 2, "R7 two timeouts", n_tmo, 2);
        check(n_rst_ep == 2, "R7 retry reset", n_rst_ep, 2);
        check(n_err == 1 && n_rng == 0 && n_done == 0, "R7 final error", n_err, 1);
        force_low = 1'b0;
        timeout_cycles = 16'd400;
        wait_locked();
    endtask

    initial begin
        clear_mon();
        repeat (4) tick();
        rst_n = 1'b1;
        t_reset();
        t_range_reject();
        t_accept(6, 1, 3);
        t_accept(104, 5, 4);
        t_postscale();
        t_busy_ignore();
        t_lock_loss();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule